// File: doc/BRIEF.md
# Per-Phase Reactive Power Sign-Change Interrupt

This block follows the direction of reactive power on three phases, A, B and C. Each phase has two energy accumulators, one for total power and one for fundamental power. Each accumulator emits a one-cycle threshold pulse together with the sign of its accumulated energy at that moment. A mode bit picks which of the two streams is watched.

On each selected pulse, the block compares the new sign of that phase with the sign it stored for that phase. When the two differ, it latches a change-of-sign status bit. The new sign is stored on every pulse. Status bits are cleared by writing ones to them. A mask register decides which status bits drive an active-low interrupt line.

Software reads four small registers through a plain read/write port. It reads the status register first and then the sign register, to learn which phase flipped and which way it went.

Top module: `psc_sign_irq`

## Requirements
- R1: After a synchronous reset, the status, mask, sign and mode registers all read 0, the stored sign of every phase is positive, and `irq_n` is high.
- R2: With the mode bit (bit 0 of the mode register at address 3) at 0, only the total-power pulse and sign inputs are used, and fundamental-power events have no effect.
- R3: With the mode bit at 1, only the fundamental-power pulse and sign inputs are used, and total-power events have no effect.
- R4: A selected pulse whose sign differs from the stored sign of its phase sets that phase's status bit on the next clock edge. The status register is at address 0, with C, B and A at bits 12, 11 and 10.
- R5: A selected pulse whose sign equals the stored sign of its phase does not set the status bit.
- R6: The sign register is at address 2, with C, B and A at bits 6, 5 and 4. A 0 means positive and a 1 means negative. Each sign bit takes the pulse's sign on every selected pulse of its phase, whatever the mask, and on the same edge as any status set.
- R7: The mask is at address 1, bits 12:10, in phase order C, B, A. `irq_n` is low exactly while some status bit and its mask bit are both 1.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: When a set event and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R10: The sign register is read-only, so writes to address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| tot_pulse | input | 3 | Total-power threshold pulses, index 0 = A |
| tot_neg | input | 3 | Sign of total energy at pulse, 1 = negative |
| fund_pulse | input | 3 | Fundamental-power threshold pulses |
| fund_neg | input | 3 | Sign of fundamental energy at pulse |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong stored sign shows up on the port as a status bit that sets on the wrong pulse. The sign register shows the stored value directly, so the fault can be read one cycle after the pulse that exposed it. A wrong source selection, a wrong mask or a lost clear shows up at `irq_n` and in the status read on the first edge after the stimulus. For this reason every step of the sweep compares the status, the sign and `irq_n` against a model one cycle later.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int NPH      = 3;
    localparam int STAT_LSB = 10;
    localparam int SIGN_LSB = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 2'd0,
        REG_MASK = 2'd1,
        REG_SIGN = 2'd2,
        REG_MODE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        SRC_TOTAL = 1'b0,
        SRC_FUND  = 1'b1
    } src_e;

    typedef struct packed {
        logic [NPH-1:0] pulse;
        logic [NPH-1:0] neg;
    } evt_t;

    function automatic logic [DATA_W-1:0] place(input logic [NPH-1:0] bits, input int lsb);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < NPH; i++) r[lsb+i] = bits[i];
        return r;
    endfunction

    function automatic logic [NPH-1:0] pick(input logic [DATA_W-1:0] word, input int lsb);
        logic [NPH-1:0] r;
        for (int i = 0; i < NPH; i++) r[i] = word[lsb+i];
        return r;
    endfunction
endpackage

// File: rtl/psc_src_sel.sv
module psc_src_sel
    import psc_pkg::*;
(
    input  src_e mode,
    input  evt_t tot,
    input  evt_t fund,
    output evt_t sel
);
    for (genvar g = 0; g < NPH; g++) begin : g_ph
        always_comb begin
            if (mode == SRC_FUND) begin
                sel.pulse[g] = fund.pulse[g];
                sel.neg[g]   = fund.neg[g];
            end else begin
                sel.pulse[g] = tot.pulse[g];
                sel.neg[g]   = tot.neg[g];
            end
        end
    end
endmodule

// File: rtl/psc_phase_track.sv
module psc_phase_track (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    input  logic neg,
    input  logic clr,
    output logic stat,
    output logic sign
);
    logic flip;
    assign flip = pulse && (neg != sign);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= 1'b0;
            sign <= 1'b0;
        end else begin
            if (pulse) sign <= neg;
            if (flip)     stat <= 1'b1;
            else if (clr) stat <= 1'b0;
        end
    end

    a_r4_flip_sets: assert property (@(posedge clk) disable iff (rst)
        pulse && (neg != sign) |=> stat);
    a_r5_same_sign_quiet: assert property (@(posedge clk) disable iff (rst)
        pulse && (neg == sign) && !stat && !clr |=> !stat);
    a_r6_sign_follows: assert property (@(posedge clk) disable iff (rst)
        pulse |=> sign == $past(neg));
    a_r6_sign_holds: assert property (@(posedge clk) disable iff (rst)
        !pulse |=> $stable(sign));
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        clr && !pulse |=> !stat);
endmodule

// File: rtl/psc_irq_gen.sv
module psc_irq_gen
    import psc_pkg::*;
(
    input  logic [NPH-1:0] stat,
    input  logic [NPH-1:0] mask,
    output logic           irq_n
);
    logic [NPH-1:0] hit;
    for (genvar g = 0; g < NPH; g++) begin : g_hit
        assign hit[g] = stat[g] & mask[g];
    end
    assign irq_n = ~(|hit);
endmodule

// File: rtl/psc_sign_irq.sv
module psc_sign_irq
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NPH-1:0]    tot_pulse,
    input  logic [NPH-1:0]    tot_neg,
    input  logic [NPH-1:0]    fund_pulse,
    input  logic [NPH-1:0]    fund_neg,
    output logic              irq_n
);
    src_e           mode_q;
    logic [NPH-1:0] mask_q;
    logic [NPH-1:0] stat_v;
    logic [NPH-1:0] sign_v;
    logic [NPH-1:0] clr_v;
    evt_t           tot_e, fund_e, sel_e;

    assign tot_e.pulse  = tot_pulse;
    assign tot_e.neg    = tot_neg;
    assign fund_e.pulse = fund_pulse;
    assign fund_e.neg   = fund_neg;

    assign clr_v = (wr_en && reg_addr_e'(wr_addr) == REG_STAT) ? pick(wr_data, STAT_LSB) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SRC_TOTAL;
            mask_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_MASK: mask_q <= pick(wr_data, STAT_LSB);
                REG_MODE: mode_q <= src_e'(wr_data[0]);
                default:  ;
            endcase
        end
    end

    psc_src_sel u_sel (
        .mode (mode_q),
        .tot  (tot_e),
        .fund (fund_e),
        .sel  (sel_e)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        psc_phase_track u_trk (
            .clk   (clk),
            .rst   (rst),
            .pulse (sel_e.pulse[g]),
            .neg   (sel_e.neg[g]),
            .clr   (clr_v[g]),
            .stat  (stat_v[g]),
            .sign  (sign_v[g])
        );
    end

    psc_irq_gen u_irq (
        .stat  (stat_v),
        .mask  (mask_q),
        .irq_n (irq_n)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            REG_STAT: rd_data = place(stat_v, STAT_LSB);
            REG_MASK: rd_data = place(mask_q, STAT_LSB);
            REG_SIGN: rd_data = place(sign_v, SIGN_LSB);
            default:  rd_data = {{(DATA_W-1){1'b0}}, mode_q};
        endcase
    end

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_v == '0 && sign_v == '0 && mask_q == '0 && irq_n));
    a_r10_sign_ro: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == REG_SIGN && sel_e.pulse == '0 |=> $stable(sign_v));
    a_r7_irq_release: assert property (@(posedge clk) disable iff (rst)
        !wr_en && sel_e.pulse == '0 && (stat_v & mask_q) == '0 |=> irq_n);
endmodule

// File: tb/sim_psc_sign_irq.sv
module sim_psc_sign_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic [2:0]  tot_pulse, tot_neg, fund_pulse, fund_neg;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [2:0] e_stat = '0, e_sign = '0, e_mask = '0;
    logic       e_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psc_sign_irq u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tot_pulse(tot_pulse), .tot_neg(tot_neg),
        .fund_pulse(fund_pulse), .fund_neg(fund_neg), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic read(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic step(input logic [2:0] tp, input logic [2:0] tn, input logic [2:0] fp,
                        input logic [2:0] fn, input logic we, input logic [1:0] wa,
                        input logic [15:0] wd, input string stag);
        logic [2:0] p, n, clr, ns;
        logic [15:0] d;
        @(negedge clk);
        tot_pulse = tp; tot_neg = tn; fund_pulse = fp; fund_neg = fn;
        wr_en = we; wr_addr = wa; wr_data = wd;
        p   = e_mode ? fp : tp;
        n   = e_mode ? fn : tn;
        clr = (we && wa == 2'd0) ? wd[12:10] : 3'b000;
        for (int i = 0; i < 3; i++) begin
            ns[i] = (p[i] && n[i] != e_sign[i]) ? 1'b1 : (clr[i] ? 1'b0 : e_stat[i]);
            if (p[i]) e_sign[i] = n[i];
        end
        e_stat = ns;
        if (we && wa == 2'd1) e_mask = wd[12:10];
        if (we && wa == 2'd3) e_mode = wd[0];
        @(posedge clk);
        #1;
        wr_en = 1'b0; tot_pulse = '0; fund_pulse = '0;
        read(2'd0, d); check(stag, d, {3'b000, e_stat, 10'b0});
        read(2'd2, d); check("R6 sign", d, {9'b0, e_sign, 4'b0});
        check("R7 irq", {15'b0, irq_n}, {15'b0, ~(|(e_stat & e_mask))});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        tot_pulse = 0; tot_neg = 0; fund_pulse = 0; fund_neg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        read(2'd0, d); check("R1 status", d, 16'h0);
        read(2'd1, d); check("R1 mask", d, 16'h0);
        read(2'd2, d); check("R1 sign", d, 16'h0);
        read(2'd3, d); check("R1 mode", d, 16'h0);
        check("R1 irq", {15'b0, irq_n}, 16'h1);

        // R10: write to sign register ignored
        step(0, 0, 0, 0, 1, 2'd2, 16'hFFFF, "R10 status");
        read(2'd2, d); check("R10 sign unchanged", d, 16'h0);
        // R2: mode 0 ignores fundamental events
        step(3'b000, 3'b000, 3'b111, 3'b111, 1, 2'd1, 16'h1C00, "R2 status");
        step(3'b000, 3'b000, 3'b111, 3'b111, 0, 2'd0, 16'h0, "R2 fund ignored");
        // R3: mode 1 uses fundamental, total ignored
        step(0, 0, 0, 0, 1, 2'd3, 16'h0001, "R3 mode write");
        step(3'b111, 3'b111, 3'b000, 3'b000, 0, 2'd0, 16'h0, "R3 total ignored");
        step(3'b000, 3'b000, 3'b001, 3'b001, 0, 2'd0, 16'h0, "R3 fund A flips");
        // R8: write 0 keeps, write 1 clears
        step(0, 0, 0, 0, 1, 2'd0, 16'h0000, "R8 write zero keeps");
        step(0, 0, 0, 0, 1, 2'd0, 16'h0400, "R8 write one clears");
        // R5: same sign again does not set
        step(3'b000, 3'b000, 3'b001, 3'b001, 0, 2'd0, 16'h0, "R5 same sign");
        // R9: set beats clear
        step(3'b000, 3'b000, 3'b001, 3'b000, 1, 2'd0, 16'h1C00, "R9 set wins");
        read(2'd0, d); check("R9 bit A kept", d & 16'h0400, 16'h0400);

        // near-exhaustive sweep over both modes and all pulse/sign patterns
        for (int m = 0; m < 2; m++) begin
            step(0, 0, 0, 0, 1, 2'd3, 16'(m), "R4 mode set");
            for (int i = 0; i < 4096; i++) begin
                logic we;
                logic [1:0] wa;
                logic [15:0] wd;
                we = 0; wa = 0; wd = 0;
                if (i % 64 == 0) begin
                    we = 1; wa = 2'd1; wd = 16'(((i >> 6) & 7) << 10);
                end else if (i % 3 == 0) begin
                    we = 1; wa = 2'd0; wd = 16'(((i >> 3) & 7) << 10);
                end else if (i % 97 == 5) begin
                    we = 1; wa = 2'd2; wd = 16'h0070;
                end
                step(3'(i), 3'(i >> 3), 3'(i >> 6), 3'(i >> 9), we, wa, wd, "R4 status");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule